// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the erase-handling slice of the device side of a serial flash that speaks SPI mode 0. While chip select is held low it assembles bytes from the data input, most significant bit first. One bit is taken on each cycle where the serial-clock rising-edge strobe is high. It recognises two erase commands.

The first is a sector erase: a single opcode followed by three address bytes that name a sector. The second is a whole-array erase, which is a fixed four-byte opcode sequence. Nothing happens until chip select returns high after a complete, well-formed command. At that point a self-timed erase interval begins, and it is modelled by a down-counter whose length is set by a parameter.

During the interval the status byte reports not-ready. When the interval ends, a one-cycle clear strobe with a sector mask is sent toward a behavioural memory array. A per-sector protection mask, qualified by a write-protect pin, decides which sectors the clear may touch. That decision is frozen at the moment the erase starts.

Top module: `spiFlashEraseCtrl`

## Requirements
- R1: After reset, `status` reads 0x80 (bit 7 = ready flag, 1 when idle; bits 6:0 always 0) and `clrStrobe` is 0 with `clrMask` all zero.
- R2: A sector erase is opcode 0x7C followed by exactly three address bytes forming a 24-bit address A23..A0, first byte most significant. The page field is A17..A11. A23..A18 and A10..A0 are ignored. For a nonzero sector number A17..A15 = k (1..7), the target is mask bit k+1, and A14..A11 have no effect.
- R3: When A17..A15 = 0, a page field of all zeros targets sub-sector 0a (mask bit 0). Any other page field with A17..A15 = 0 targets sub-sector 0b (mask bit 1).
- R4: A whole-array erase is recognised only for the bytes 0xC7, 0x94, 0x80, 0x9A in that order. Bytes clocked after the fourth are ignored. The target is every sector (mask bits 8..0).
- R5: No erase starts while chip select stays low. The erase starts on the clock cycle that sees chip select high after having been low, and `status` bit 7 reads 0 from the following cycle.
- R6: `status` bit 7 reads 0 for exactly SECT_CYC cycles for a sector erase and CHIP_CYC cycles for a whole-array erase. Bits 6:0 stay 0 throughout.
- R7: When an erase ends, `clrStrobe` pulses for one cycle, in the first cycle `status` bit 7 reads 1 again. The pulse carries the unprotected targets on `clrMask`. It does not pulse if that set is empty. `clrMask` is zero whenever `clrStrobe` is 0.
- R8: A command is discarded with no busy period in each of these cases: chip select rises before all three address bytes arrive; any byte of the four-byte sequence is wrong or missing; chip select rises part-way through a byte; or a fourth byte follows the sector address.
- R9: Sector i is protected when `protMask[i]`=1 and `wpN`=0 at erase start. A whole-array erase clears only unprotected sectors. A sector erase aimed at a protected sector still runs its full busy time but issues no clear.
- R10: Changes on `wpN` or `protMask` during a busy period do not change the clear issued at its end. They apply from the next erase.
- R11: An erase command completed and terminated while busy is ignored: no second busy period and no second clear follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low, synchronous to clk |
| sckRise | input | 1 | One-cycle strobe marking a serial-clock rising edge |
| sdi | input | 1 | Serial data input, sampled when sckRise is high |
| wpN | input | 1 | Write-protect pin, active low |
| protMask | input | 9 | Per-sector protect bits: bit 0 = 0a, bit 1 = 0b, bit k+1 = sector k |
| status | output | 8 | Status byte, bit 7 = ready |
| clrStrobe | output | 1 | One-cycle request to clear the sectors in clrMask |
| clrMask | output | 9 | Sectors to clear, same bit order as protMask |

## Verification
The in-RTL assertions check the following on every cycle:
- the clear strobe is a single pulse that lines up with the return of ready and carries a nonzero mask;
- a busy period only begins right after a chip-select rise on a byte boundary;
- the frozen target mask stays constant while busy;
- the erase timer is only reloaded when idle and never expires outside a busy period.

Only the directed scenarios can show the following:
- that the exact busy lengths are right and that each opcode byte sequence is decoded;
- how the page field maps onto sub-sectors 0a and 0b;
- that incomplete commands and commands issued while busy are discarded;
- that a write-protect change made mid-erase waits for the next erase.

// File: rtl/sfErasePkg.sv
package sfErasePkg;

  localparam int PAGE_BITS  = 7;
  localparam int SECT_BITS  = 3;
  localparam int PAGE_LSB   = 11;
  localparam int NSEC       = (1 << SECT_BITS) + 1;
  localparam int HI_BITS    = PAGE_LSB + PAGE_BITS - 16;
  localparam int LO_BITS    = PAGE_BITS - HI_BITS;
  localparam int ADDR_BYTES = 3;

  localparam logic [7:0] OPC_SECTOR = 8'h7C;
  localparam logic [3:0][7:0] CHIP_SEQ = {8'h9A, 8'h80, 8'h94, 8'hC7};

  typedef enum logic [2:0] {
    D_OPC,
    D_ADDR,
    D_CHIP,
    D_SECT_OK,
    D_CHIP_OK,
    D_JUNK
  } decodeT;

  typedef struct packed {
    logic capHi;
    logic capLo;
    logic timerLoad;
    logic timerChip;
  } sfCtlT;

  function automatic logic [NSEC-1:0] sectHotF(input logic [PAGE_BITS-1:0] pg);
    logic [NSEC-1:0] h;
    logic [SECT_BITS-1:0] s;
    h = '0;
    s = pg[PAGE_BITS-1 -: SECT_BITS];
    if (s == '0) begin
      if (pg == '0) h[0] = 1'b1;
      else          h[1] = 1'b1;
    end else begin
      h[int'(s) + 1] = 1'b1;
    end
    return h;
  endfunction

endpackage

// File: rtl/sfEraseDataPath.sv
module sfEraseDataPath
  import sfErasePkg::*;
#(
  parameter int SECT_CYC = 100,
  parameter int CHIP_CYC = 160
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sckRise,
  input  logic            sdi,
  input  sfCtlT           ctl,
  output logic            byteValid,
  output logic [7:0]      byteData,
  output logic            csRise,
  output logic            midByte,
  output logic [NSEC-1:0] sectHot,
  output logic            timerDone
);

  localparam int MAXC = (SECT_CYC > CHIP_CYC) ? SECT_CYC : CHIP_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [6:0]           shReg;
  logic [2:0]           bitCnt;
  logic                 csPrev;
  logic [PAGE_BITS-1:0] pageReg;
  logic [TW-1:0]        timer;

  // serial byte assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      csPrev <= 1'b1;
    end else begin
      csPrev <= csN;
      if (csN) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shReg  <= {shReg[5:0], sdi};
        bitCnt <= bitCnt + 3'd1;
      end
    end
  end

  assign byteData  = {shReg, sdi};
  assign byteValid = !csN && sckRise && (bitCnt == 3'd7);
  assign csRise    = csN && !csPrev;
  assign midByte   = (bitCnt != 3'd0);

  // page field capture: A17..A16 from first address byte, A15..A11 from second
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
    end else begin
      if (ctl.capHi) pageReg[PAGE_BITS-1 -: HI_BITS] <= byteData[HI_BITS-1:0];
      if (ctl.capLo) pageReg[LO_BITS-1:0] <= byteData[7 -: LO_BITS];
    end
  end

  assign sectHot = sectHotF(pageReg);

  // self-timed erase interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (ctl.timerLoad) begin
      timer <= ctl.timerChip ? TW'(CHIP_CYC) : TW'(SECT_CYC);
    end else if (timer != '0) begin
      timer <= timer - TW'(1);
    end
  end

  assign timerDone = (timer == TW'(1));

  a_r6_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TW'(MAXC));

  a_r6_load_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.timerLoad |-> (timer == '0));

  a_r8_no_capture_mid_byte: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capHi || ctl.capLo) |-> (bitCnt == 3'd7));

endmodule

// File: rtl/sfEraseCtl.sv
module sfEraseCtl
  import sfErasePkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            byteValid,
  input  logic [7:0]      byteData,
  input  logic            csRise,
  input  logic            midByte,
  input  logic [NSEC-1:0] sectHot,
  input  logic            timerDone,
  input  logic            wpN,
  input  logic [NSEC-1:0] protMask,
  output sfCtlT           ctl,
  output logic [7:0]      status,
  output logic            clrStrobe,
  output logic [NSEC-1:0] clrMask
);

  decodeT          dec, decN;
  logic [1:0]      chipIdx, chipIdxN;
  logic [1:0]      addrCnt, addrCntN;
  logic            busy;
  logic            startOk;
  logic [NSEC-1:0] pendMask;
  logic [NSEC-1:0] protEff;
  logic [NSEC-1:0] target;

  // command byte decoder
  always_comb begin
    decN     = dec;
    chipIdxN = chipIdx;
    addrCntN = addrCnt;
    ctl      = '0;
    if (byteValid) begin
      case (dec)
        D_OPC: begin
          if (byteData == OPC_SECTOR) begin
            decN     = D_ADDR;
            addrCntN = 2'd0;
          end else if (byteData == CHIP_SEQ[0]) begin
            decN     = D_CHIP;
            chipIdxN = 2'd1;
          end else begin
            decN = D_JUNK;
          end
        end
        D_ADDR: begin
          ctl.capHi = (addrCnt == 2'd0);
          ctl.capLo = (addrCnt == 2'd1);
          if (addrCnt == 2'(ADDR_BYTES - 1)) decN = D_SECT_OK;
          else addrCntN = addrCnt + 2'd1;
        end
        D_CHIP: begin
          if (byteData == CHIP_SEQ[chipIdx]) begin
            if (chipIdx == 2'd3) decN = D_CHIP_OK;
            else chipIdxN = chipIdx + 2'd1;
          end else begin
            decN = D_JUNK;
          end
        end
        D_SECT_OK: decN = D_JUNK;
        default:   decN = dec;
      endcase
    end

    startOk       = csRise && !midByte && !busy &&
                    ((dec == D_SECT_OK) || (dec == D_CHIP_OK));
    ctl.timerLoad = startOk;
    ctl.timerChip = (dec == D_CHIP_OK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dec     <= D_OPC;
      chipIdx <= '0;
      addrCnt <= '0;
    end else if (csN) begin
      dec     <= D_OPC;
      chipIdx <= '0;
      addrCnt <= '0;
    end else begin
      dec     <= decN;
      chipIdx <= chipIdxN;
      addrCnt <= addrCntN;
    end
  end

  // protection is frozen when the erase starts
  assign protEff = wpN ? '0 : protMask;
  assign target  = (ctl.timerChip ? {NSEC{1'b1}} : sectHot) & ~protEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pendMask  <= '0;
      clrStrobe <= 1'b0;
      clrMask   <= '0;
    end else begin
      clrStrobe <= timerDone && busy && (pendMask != '0);
      clrMask   <= (timerDone && busy) ? pendMask : '0;
      if (startOk) begin
        busy     <= 1'b1;
        pendMask <= target;
      end else if (timerDone) begin
        busy     <= 1'b0;
      end
    end
  end

  assign status = {!busy, 7'b0};

  a_r5_start_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));

  a_r8_start_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(midByte));

  a_r7_strobe_at_ready: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |-> (status[7] && $past(busy)));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |=> !clrStrobe);

  a_r7_strobe_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |-> (clrMask != '0));

  a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !clrStrobe |-> (clrMask == '0));

  a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(pendMask));

  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |-> busy);

endmodule

// File: rtl/spiFlashEraseCtrl.sv
module spiFlashEraseCtrl
  import sfErasePkg::*;
#(
  parameter int SECT_CYC = 100,
  parameter int CHIP_CYC = 160
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sckRise,
  input  logic            sdi,
  input  logic            wpN,
  input  logic [NSEC-1:0] protMask,
  output logic [7:0]      status,
  output logic            clrStrobe,
  output logic [NSEC-1:0] clrMask
);

  sfCtlT           ctl;
  logic            byteValid;
  logic [7:0]      byteData;
  logic            csRise;
  logic            midByte;
  logic [NSEC-1:0] sectHot;
  logic            timerDone;

  sfEraseDataPath #(.SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) i_dataPath (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sckRise   (sckRise),
    .sdi       (sdi),
    .ctl       (ctl),
    .byteValid (byteValid),
    .byteData  (byteData),
    .csRise    (csRise),
    .midByte   (midByte),
    .sectHot   (sectHot),
    .timerDone (timerDone)
  );

  sfEraseCtl i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .byteValid (byteValid),
    .byteData  (byteData),
    .csRise    (csRise),
    .midByte   (midByte),
    .sectHot   (sectHot),
    .timerDone (timerDone),
    .wpN       (wpN),
    .protMask  (protMask),
    .ctl       (ctl),
    .status    (status),
    .clrStrobe (clrStrobe),
    .clrMask   (clrMask)
  );

endmodule

// File: tb/test_spiFlashEraseCtrl.sv
module test_spiFlashEraseCtrl;

  localparam int SECT_CYC = 100;
  localparam int CHIP_CYC = 160;
  localparam int NSEC     = 9;
  localparam logic [NSEC-1:0] ALL = {NSEC{1'b1}};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            csN = 1'b1;
  logic            sckRise = 1'b0;
  logic            sdi = 1'b0;
  logic            wpN = 1'b1;
  logic [NSEC-1:0] protMask = '0;
  logic [7:0]      status;
  logic            clrStrobe;
  logic [NSEC-1:0] clrMask;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  spiFlashEraseCtrl #(.SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) i_spiFlashEraseCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sckRise(sckRise), .sdi(sdi),
    .wpN(wpN), .protMask(protMask), .status(status),
    .clrStrobe(clrStrobe), .clrMask(clrMask)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input bit b);
    sdi = b;
    sckRise = 1'b1;
    @(negedge clk);
    sckRise = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic select();
    csN = 1'b0;
    @(negedge clk);
  endtask

  task automatic deselect();
    csN = 1'b1;
  endtask

  function automatic logic [23:0] mkAddr(input logic [6:0] page);
    return {6'h3F, page, 11'h7FF};
  endfunction

  task automatic sendSector(input logic [6:0] page);
    logic [23:0] a;
    a = mkAddr(page);
    sendByte(8'h7C);
    sendByte(a[23:16]);
    sendByte(a[15:8]);
    sendByte(a[7:0]);
  endtask

  task automatic sendChip();
    sendByte(8'hC7);
    sendByte(8'h94);
    sendByte(8'h80);
    sendByte(8'h9A);
  endtask

  // called right after deselect(); measures busy length and the clear pulse
  task automatic waitErase(input int expCyc, input logic [NSEC-1:0] expMask,
                           input bit chkCnt, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (status[7] == 1'b0 && n < CHIP_CYC + 50) begin
      check(status[6:0] == 7'b0, {tag, " status low bits"}, status, 8'h00);
      n++;
      @(negedge clk);
    end
    if (chkCnt) check(n == expCyc, {tag, " busy length"}, n, expCyc);
    check(clrStrobe == (expMask != '0), {tag, " strobe at ready"}, clrStrobe, (expMask != '0));
    check(clrMask == expMask, {tag, " clear mask"}, clrMask, expMask);
    @(negedge clk);
    check(clrStrobe == 1'b0 && clrMask == '0, {tag, " single pulse"}, clrStrobe, 0);
  endtask

  task automatic waitNone(input int len, input string tag);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (status != 8'h80 || clrStrobe) bad = 1'b1;
    end
    check(!bad, {tag, " no erase"}, bad, 0);
  endtask

  task automatic t_reset();
    check(status == 8'h80, "R1 status", status, 8'h80);
    check(clrStrobe == 1'b0 && clrMask == '0, "R1 clear idle", clrMask, 0);
  endtask

  task automatic t_sectors();
    select(); sendSector(7'b101_0110); deselect();
    waitErase(SECT_CYC, NSEC'(1) << 6, 1'b1, "R2 sector5");
    select(); sendSector(7'b111_1111); deselect();
    waitErase(SECT_CYC, NSEC'(1) << 8, 1'b1, "R2 sector7");
    select(); sendSector(7'b001_0000); deselect();
    waitErase(SECT_CYC, NSEC'(1) << 2, 1'b1, "R2 sector1");
    select(); sendSector(7'b000_0000); deselect();
    waitErase(SECT_CYC, NSEC'(1), 1'b1, "R3 sub0a");
    select(); sendSector(7'b000_0011); deselect();
    waitErase(SECT_CYC, NSEC'(2), 1'b1, "R3 sub0b");
  endtask

  task automatic t_chip();
    select(); sendChip(); sendByte(8'h55); sendByte(8'hFF); deselect();
    waitErase(CHIP_CYC, ALL, 1'b1, "R4 chip extra bytes");
    select(); sendByte(8'hC7); sendByte(8'h94); sendByte(8'h9A); sendByte(8'h80); deselect();
    waitNone(CHIP_CYC + 10, "R4 wrong order");
  endtask

  task automatic t_holdLow();
    select(); sendSector(7'b010_0000);
    repeat (SECT_CYC + 10) @(negedge clk);
    check(status == 8'h80, "R5 no start while selected", status, 8'h80);
    deselect();
    @(negedge clk);
    check(status == 8'h00, "R5 busy after rise", status, 8'h00);
    waitErase(SECT_CYC - 1, NSEC'(1) << 3, 1'b1, "R5 sector2");
  endtask

  task automatic t_incomplete();
    logic [23:0] a;
    a = mkAddr(7'b011_0000);
    select(); sendByte(8'h7C); sendByte(a[23:16]); sendByte(a[15:8]); deselect();
    waitNone(SECT_CYC + 10, "R8 short address");
    select(); sendByte(8'hC7); sendByte(8'h94); sendByte(8'h80); deselect();
    waitNone(CHIP_CYC + 10, "R8 short chip seq");
    select(); sendSector(7'b011_0000); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); deselect();
    waitNone(SECT_CYC + 10, "R8 mid byte");
    select(); sendSector(7'b011_0000); sendByte(8'h00); deselect();
    waitNone(SECT_CYC + 10, "R8 extra address byte");
  endtask

  task automatic t_protect();
    protMask = 9'b0_0100_0001;
    wpN = 1'b0;
    select(); sendChip(); deselect();
    waitErase(CHIP_CYC, ALL & ~9'b0_0100_0001, 1'b1, "R9 chip skips protected");
    select(); sendSector(7'b101_0000); deselect();
    waitErase(SECT_CYC, '0, 1'b1, "R9 protected sector");
    wpN = 1'b1;
    select(); sendSector(7'b101_0000); deselect();
    waitErase(SECT_CYC, NSEC'(1) << 6, 1'b1, "R9 wp released");
  endtask

  task automatic t_wpDuring();
    protMask = 9'b1_0000_0010;
    wpN = 1'b1;
    select(); sendChip(); deselect();
    repeat (20) @(negedge clk);
    wpN = 1'b0;
    protMask = 9'b1_1111_1111;
    waitErase(CHIP_CYC - 20, ALL, 1'b1, "R10 wp mid erase");
    protMask = 9'b1_0000_0010;
    select(); sendChip(); deselect();
    waitErase(CHIP_CYC, ALL & ~9'b1_0000_0010, 1'b1, "R10 next erase protected");
    wpN = 1'b1;
    protMask = '0;
  endtask

  task automatic t_busyIgnore();
    select(); sendChip(); deselect();
    @(negedge clk);
    select(); sendSector(7'b100_0000); deselect();
    waitErase(0, ALL, 1'b0, "R11 first erase");
    waitNone(SECT_CYC + 20, "R11 command while busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sectors();
    t_chip();
    t_holdLow();
    t_incomplete();
    t_protect();
    t_wpDuring();
    t_busyIgnore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule